// File: doc/BRIEF.md
# Instruction Address Exact-Match Comparator

This block watches the stream of instruction addresses handed to a trace unit and raises a one-cycle match pulse when an address falls inside a programmed masked address window. Each presented instruction carries a pipeline-stage tag, either fetch or execute, and execute-stage instructions also carry a canceled flag. Whether a canceled instruction may match is governed by an exact-match enable held in the comparator's configuration register.

For variable-length bytecodes the block receives separate start and end events. With exact match off, the match is reported as soon as a bytecode starts. With exact match on, the decision waits for the end event, so that an interrupted bytecode produces no match. A pending flag carries the start-time address result across the bytecode. Instructions that are never presented, such as aborted prefetches that the trace side drops, carry no address and so never match.

Top module: `iaddr_xmatch`

## Requirements
- R1: A write strobe loads the compare value, the mask and the control byte on a clock edge, and the new values govern events from the next cycle on. Bit 7 of the control byte is the exact-match enable. While the strobe is low, the configuration inputs have no effect.
- R2: An address hits when every bit that is set in the mask agrees with the compare value. Bits that are clear in the mask are don't-care.
- R3: Stage tag 0 means fetch. A fetch-stage instruction that hits matches whatever the canceled flag and the exact-match enable say.
- R4: Stage tag 1 means execute. With exact match off, an execute-stage instruction that hits matches whether or not it is canceled.
- R5: With exact match on, an execute-stage instruction that hits matches only if it is not canceled.
- R6: The match output is registered: it is high for the cycle after a qualifying event and low in any cycle that follows a cycle with no instruction and no bytecode event.
- R7: With exact match off, a bytecode start whose address (taken from the instruction address input) hits matches in the next cycle, and the corresponding end event produces no match.
- R8: With exact match on, a bytecode start produces no match. The following end event produces a match in the next cycle if the start address hit and the interrupted flag is low.
- R9: An end event with the interrupted flag high clears the pending state without a match. A later end event with no new start does not match.
- R10: A synchronous active-low reset clears the compare value and the mask to zero, turns exact match off, clears the pending state and holds the match output low.
- R11: When end and start arrive in the same cycle, the end event is resolved against the earlier start, and the new start arms the pending state for the next end event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cmp_i | input | AW | Compare address to load |
| cfg_mask_i | input | AW | Address mask to load (1 = compared bit) |
| cfg_ctrl_i | input | CW | Control byte to load; bit XB is the exact-match enable |
| ins_valid_i | input | 1 | Instruction presented for comparison |
| ins_addr_i | input | AW | Instruction address; also the address of a starting bytecode |
| ins_exec_i | input | 1 | Stage tag: 0 fetch, 1 execute |
| ins_cancel_i | input | 1 | Execute-stage instruction was canceled |
| bc_start_i | input | 1 | Bytecode start event |
| bc_end_i | input | 1 | Bytecode end event |
| bc_intr_i | input | 1 | The ending bytecode was interrupted |
| match_o | output | 1 | Registered match pulse |

## Verification
The bench builds the block with a 4-bit address. At that width it can sweep every address against every compare value under four distinct masks, in both stages, with and without cancellation, and with exact match both off and on. Bytecode sequences are swept over exact mode, hit or miss, the interrupted flag and several gap lengths between start and end. Further directed sequences cover reset defaults, writes that happen while the strobe is low, and end and start arriving in the same cycle.

// File: rtl/xm_pkg.sv
package xm_pkg;

  typedef enum logic {
    STG_FETCH = 1'b0,
    STG_EXEC  = 1'b1
  } stage_e;

  // Exact-match qualification of a presented instruction.
  function automatic logic instr_allowed(input logic is_exec,
                                         input logic canceled,
                                         input logic exact);
    return !(is_exec && exact && canceled);
  endfunction

  // Next pending state for bytecode tracking (end resolved before start).
  function automatic logic pend_next(input logic cur, input logic start,
                                     input logic fin, input logic arm);
    if (start)    return arm;
    else if (fin) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/xm_cfg_reg.sv
module xm_cfg_reg #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int XB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] cmp_d,
  input  logic [AW-1:0] mask_d,
  input  logic [CW-1:0] ctrl_d,
  output logic [AW-1:0] cmp_q,
  output logic [AW-1:0] mask_q,
  output logic          exact_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      mask_q  <= '0;
      exact_q <= 1'b0;
    end else if (we) begin
      cmp_q   <= cmp_d;
      mask_q  <= mask_d;
      exact_q <= ctrl_d[XB];
    end
  end

endmodule

// File: rtl/xm_addr_cmp.sv
module xm_addr_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] mask,
  output logic          hit
);

  logic [AW-1:0] bit_ok;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = !mask[i] || (addr[i] == ref_addr[i]);
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/xm_bc_tracker.sv
module xm_bc_tracker
  import xm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exact,
  input  logic hit,
  input  logic start,
  input  logic fin,
  input  logic intr,
  output logic start_fire,
  output logic end_fire,
  output logic pend_q
);

  logic arm;

  assign arm        = start && exact && hit;
  assign start_fire = start && !exact && hit;
  assign end_fire   = fin && pend_q && !intr;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_next(pend_q, start, fin, arm);
  end

endmodule

// File: rtl/iaddr_xmatch.sv
module iaddr_xmatch
  import xm_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int XB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_cmp_i,
  input  logic [AW-1:0] cfg_mask_i,
  input  logic [CW-1:0] cfg_ctrl_i,
  input  logic          ins_valid_i,
  input  logic [AW-1:0] ins_addr_i,
  input  logic          ins_exec_i,
  input  logic          ins_cancel_i,
  input  logic          bc_start_i,
  input  logic          bc_end_i,
  input  logic          bc_intr_i,
  output logic          match_o
);

  logic [AW-1:0] cmp_q;
  logic [AW-1:0] mask_q;
  logic          exact_q;
  logic          hit_w;
  logic          instr_fire_w;
  logic          start_fire_w;
  logic          end_fire_w;
  logic          pend_q;
  logic          match_d;
  logic          match_q;
  stage_e        stage_w;

  xm_cfg_reg #(.AW(AW), .CW(CW), .XB(XB)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .cmp_d   (cfg_cmp_i),
    .mask_d  (cfg_mask_i),
    .ctrl_d  (cfg_ctrl_i),
    .cmp_q   (cmp_q),
    .mask_q  (mask_q),
    .exact_q (exact_q)
  );

  xm_addr_cmp #(.AW(AW)) u_cmp (
    .addr     (ins_addr_i),
    .ref_addr (cmp_q),
    .mask     (mask_q),
    .hit      (hit_w)
  );

  xm_bc_tracker u_bc (
    .clk        (clk),
    .rst_n      (rst_n),
    .exact      (exact_q),
    .hit        (hit_w),
    .start      (bc_start_i),
    .fin        (bc_end_i),
    .intr       (bc_intr_i),
    .start_fire (start_fire_w),
    .end_fire   (end_fire_w),
    .pend_q     (pend_q)
  );

  assign stage_w      = ins_exec_i ? STG_EXEC : STG_FETCH;
  assign instr_fire_w = ins_valid_i && hit_w &&
                        instr_allowed(stage_w == STG_EXEC, ins_cancel_i, exact_q);
  assign match_d      = instr_fire_w || start_fire_w || end_fire_w;

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match_o = match_q;

endmodule

// File: rtl/xm_chk.sv
module xm_chk (
  input logic clk,
  input logic rst_n,
  input logic ins_valid,
  input logic ins_exec,
  input logic ins_cancel,
  input logic bc_start,
  input logic bc_end,
  input logic bc_intr,
  input logic exact,
  input logic hit,
  input logic pend,
  input logic match
);

  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !match);

  assert_fetch_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_exec && hit |=> match);

  assert_cancel_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_exec && ins_cancel && exact && !bc_start && !bc_end |=> !match);

  assert_idle_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid && !bc_start && !bc_end |=> !match);

  assert_start_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bc_start && !exact && hit |=> match);

  assert_pend_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(bc_start && exact && hit));

  assert_intr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bc_end && bc_intr && !bc_start |=> !pend);

endmodule

bind iaddr_xmatch xm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_valid  (ins_valid_i),
  .ins_exec   (ins_exec_i),
  .ins_cancel (ins_cancel_i),
  .bc_start   (bc_start_i),
  .bc_end     (bc_end_i),
  .bc_intr    (bc_intr_i),
  .exact      (exact_q),
  .hit        (hit_w),
  .pend       (pend_q),
  .match      (match_o)
);

// File: tb/sim_iaddr_xmatch.sv
`timescale 1ns/1ps
module sim_iaddr_xmatch;

  localparam int AW = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_cmp_i = '0;
  logic [AW-1:0] cfg_mask_i = '0;
  logic [CW-1:0] cfg_ctrl_i = '0;
  logic          ins_valid_i = 1'b0;
  logic [AW-1:0] ins_addr_i = '0;
  logic          ins_exec_i = 1'b0;
  logic          ins_cancel_i = 1'b0;
  logic          bc_start_i = 1'b0;
  logic          bc_end_i = 1'b0;
  logic          bc_intr_i = 1'b0;
  logic          match_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iaddr_xmatch #(.AW(AW), .CW(CW), .XB(7)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cmp_i(cfg_cmp_i),
    .cfg_mask_i(cfg_mask_i), .cfg_ctrl_i(cfg_ctrl_i), .ins_valid_i(ins_valid_i),
    .ins_addr_i(ins_addr_i), .ins_exec_i(ins_exec_i), .ins_cancel_i(ins_cancel_i),
    .bc_start_i(bc_start_i), .bc_end_i(bc_end_i), .bc_intr_i(bc_intr_i),
    .match_o(match_o)
  );

  task automatic step(input logic v, input logic [AW-1:0] a, input logic ex,
                      input logic can, input logic bs, input logic be, input logic bi);
    ins_valid_i = v; ins_addr_i = a; ins_exec_i = ex; ins_cancel_i = can;
    bc_start_i = bs; bc_end_i = be; bc_intr_i = bi;
    @(negedge clk);
    ins_valid_i = 1'b0; bc_start_i = 1'b0; bc_end_i = 1'b0; bc_intr_i = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic check(input logic exp, input string req);
    nchk++;
    if (match_o !== exp) begin
      nfail++;
      $display("FAIL %s: match_o=%b expected %b at %0t", req, match_o, exp, $time);
    end
  endtask

  task automatic cfg(input logic [AW-1:0] c, input logic [AW-1:0] m, input logic xm);
    cfg_we = 1'b1; cfg_cmp_i = c; cfg_mask_i = m; cfg_ctrl_i = {xm, 7'h55};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic hits(input logic [AW-1:0] a, input logic [AW-1:0] c,
                                input logic [AW-1:0] m);
    return ((a ^ c) & m) == '0;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] m;
    logic exp;
    repeat (3) @(negedge clk);
    check(1'b0, "R10 match low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R10 match low after reset");
    // Reset config: mask 0, exact off -> canceled execute instruction at any address matches
    step(1'b1, 4'h9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R10 reset defaults mask zero exact off");

    // R1: inputs without strobe are ignored
    cfg(4'h3, 4'hF, 1'b0);
    cfg_cmp_i = 4'hC; cfg_ctrl_i = 8'h80;
    step(1'b1, 4'hC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b0, "R1 compare held without strobe");
    step(1'b1, 4'h3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R1 exact held off without strobe");

    // Exhaustive instruction sweep: R2, R3, R4, R5, R6
    for (int xm = 0; xm < 2; xm++)
      for (int c = 0; c < 16; c++)
        for (int mi = 0; mi < 4; mi++) begin
          m = (mi == 0) ? 4'hF : (mi == 1) ? 4'h0 : (mi == 2) ? 4'h5 : 4'hC;
          cfg(c[AW-1:0], m, xm[0]);
          for (int a = 0; a < 16; a++)
            for (int ex = 0; ex < 2; ex++)
              for (int cn = 0; cn < 2; cn++) begin
                exp = hits(a[AW-1:0], c[AW-1:0], m) && (ex == 0 || xm == 0 || cn == 0);
                step(1'b1, a[AW-1:0], ex[0], cn[0], 1'b0, 1'b0, 1'b0);
                if (ex == 0)      check(exp, "R2 R3 fetch");
                else if (xm == 0) check(exp, "R2 R4 execute exact off");
                else              check(exp, "R2 R5 execute exact on");
                if (a == 15 && cn == 1) begin
                  idle();
                  check(1'b0, "R6 no event no match");
                end
              end
        end

    // Bytecode sweep: R7, R8, R9
    for (int xm = 0; xm < 2; xm++)
      for (int h = 0; h < 2; h++)
        for (int it = 0; it < 2; it++)
          for (int gap = 0; gap < 3; gap++) begin
            cfg(4'hA, 4'hF, xm[0]);
            step(1'b0, (h != 0) ? 4'hA : 4'h2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            if (xm == 0) check(h != 0, "R7 match at bytecode start");
            else         check(1'b0, "R8 no match at start when exact");
            for (int g = 0; g < gap; g++) begin
              idle();
              check(1'b0, "R6 quiet inside bytecode");
            end
            step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, it[0]);
            if (xm == 0)     check(1'b0, "R7 no match at end when exact off");
            else if (it == 1) check(1'b0, "R9 interrupted bytecode no match");
            else             check(h != 0, "R8 match at bytecode end");
            step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check(1'b0, "R9 end without start no match");
          end

    // R11: end and start in the same cycle
    cfg(4'h6, 4'hF, 1'b1);
    step(1'b0, 4'h6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check(1'b0, "R11 first start armed");
    step(1'b0, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check(1'b1, "R11 end resolves earlier start");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(1'b1, "R11 new start armed by same-cycle start");
    step(1'b0, 4'h6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 4'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check(1'b0, "R11 interrupted end with missing start");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(1'b0, "R11 missed start leaves nothing pending");

    // R10: reset clears pending state
    step(1'b0, 4'h6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R10 match low in second reset");
    rst_n = 1'b1;
    cfg(4'h6, 4'hF, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(1'b0, "R10 pending cleared by reset");
    step(1'b1, 4'h6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b0, "R1 R5 exact bit 7 written");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule